// File: doc/BRIEF.md
# Audio Level Controller

This block controls the level of a mono stream of 16-bit signed audio samples. Each sample arrives with a valid strobe. The block scales each sample by a gain that an 8-bit code selects. Code 0x91 is unity gain, and each code step is 0.375 dB, so code 0xE1 gives +30 dB. The scaled result saturates to the 16-bit range and appears one clock later with its own valid flag.

While the enable input is high, the block adjusts the gain code on its own. It lowers the code when a scaled sample exceeds a selectable limit. It raises the code again, toward a programmed ceiling, after a run of quiet samples. A pending change can be held back until the input sign flips, with a timeout in case no flip comes. While the block is disabled, it takes a snapshot of its settings and holds the gain at the starting code, clamped to the ceiling. While it is enabled, changes to the settings are ignored.

Top module: `audio_level_ctrl`

## Requirements
- R1: When a sample is valid, one clock later `out_valid` is 1 and `out_data` = saturate_16((x * G) >>> 12), with G = round(4096 * 10^((code - 145) * 0.375 / 20)) and `code` the gain code in force when the sample was taken. A cycle with no valid sample leaves `out_valid` at 0 one clock later.
- R2: While `en` is low, the gain code settles on every clock to the smaller of `cfg_init_gain` and `cfg_ceiling`. The pending change, both counters and the stored sign are cleared.
- R3: A sample counts as over the limit when the magnitude of its scaled value is strictly above the level that `cfg_lim_sel` picks. The levels are 00: 24576, 01: 20437 (about −4.1 dBFS), 10: 16384, 11: 12288. An over-limit sample raises an attenuation target of the code minus (`cfg_att_step_sel` + 1), floored at 0, unless an attenuation is already pending.
- R4: Each valid sample that is not over the limit advances a wait count, which saturates at 128 << `cfg_wait_sel` samples. When no change is pending, the count reaches that length and the code is below the ceiling, a recovery target of min(code + `cfg_rec_step_sel` + 1, ceiling) is raised and the count restarts. The code never rises above the ceiling.
- R5: With `cfg_zc_en` = 0, a raised target takes effect on the sample that raised it, so the next sample already uses it. With `cfg_zc_en` = 1, the target takes effect on the first sample whose bit 15 differs from that of the previous valid sample (the stored sign is 0 right after enabling). If no such sample comes, it takes effect on sample number 128 << `cfg_zc_tmo_sel`, counting the raising sample as number 1.
- R6: An over-limit sample replaces a pending recovery with an attenuation target, restarting the timeout, and clears the wait count.
- R7: The limit select, step selects, wait and timeout selects, ceiling and zero-crossing enable are captured only while `en` is low. Changing them while `en` is high has no effect on behaviour.
- R8: While `en` is high, the gain code changes only on clocks that carry a valid sample.
- R9: During reset, `gain` is 0x91 and `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enable for automatic control; low captures settings |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Signed input sample |
| cfg_lim_sel | input | 2 | Limit level select |
| cfg_zc_en | input | 1 | Hold gain changes until a sign flip |
| cfg_zc_tmo_sel | input | 2 | Sign-flip timeout select, 128 << n samples |
| cfg_wait_sel | input | 2 | Recovery wait select, 128 << n samples |
| cfg_ceiling | input | 8 | Highest gain code that recovery may reach |
| cfg_init_gain | input | 8 | Gain code used while disabled |
| cfg_att_step_sel | input | 2 | Attenuation step minus one |
| cfg_rec_step_sel | input | 2 | Recovery step minus one |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Scaled, saturated sample |
| gain | output | 8 | Current gain code |

## Verification
Most internal faults show up on the `gain` port within one sample. A wrong step size, a wrong limit level or a wrong ceiling each give a code that differs from the reference model on the next clock. Faults in the counters or the stored sign hide for up to one full wait or timeout window, then appear as a gain change that comes a sample early or late. The bench compares the gain on every clock, so a shifted window shows up at its boundary. A wrong table entry or a faulty saturation shows on `out_data` one clock after the first sample scaled with the affected code.

// File: rtl/alc_pkg.sv
`timescale 1ns/1ps
package alc_pkg;

   typedef enum logic [1:0] {
      PEND_NONE = 2'd0,
      PEND_ATT  = 2'd1,
      PEND_REC  = 2'd2
   } pend_e;

   // fixed-point linear gain for a code; 0.375 dB per code around the unity code
   function automatic int gain_fixed(input int code, input int unity, input int frac);
      real db;
      real lin;
      db  = real'(code - unity) * 0.375;
      lin = 10.0 ** (db / 20.0);
      return $rtoi(lin * real'(64'd1 << frac) + 0.5);
   endfunction

endpackage

// File: rtl/alc_gain_rom.sv
`timescale 1ns/1ps
module alc_gain_rom #(
   parameter int CW    = 8,
   parameter int GW    = 20,
   parameter int FRAC  = 12,
   parameter int UNITY = 145
) (
   input  logic [CW-1:0] code,
   output logic [GW-1:0] lin
);
   localparam int DEPTH = 1 << CW;

   logic [GW-1:0] tab [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam int V = alc_pkg::gain_fixed(i, UNITY, FRAC);
      if (V >= (1 << GW)) begin : g_bad
         $error("gain table entry exceeds GW bits");
      end
      assign tab[i] = GW'(V);
   end

   assign lin = tab[code];
endmodule

// File: rtl/alc_scaler.sv
`timescale 1ns/1ps
module alc_scaler #(
   parameter int DW            = 16,
   parameter int GW            = 20,
   parameter int FRAC          = 12,
   parameter int ROUND_NEAREST = 0
) (
   input  logic signed [DW-1:0] x,
   input  logic        [GW-1:0] g,
   output logic signed [DW-1:0] y
);
   localparam int PW = DW + GW + 1;
   localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DW - 1)) - 64'sd1);
   localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);
   localparam logic signed [PW-1:0] HALF = PW'(64'd1 << (FRAC - 1));

   logic signed [PW-1:0] xs, gs, prod, shifted;

   assign xs   = PW'(x);
   assign gs   = PW'($signed({1'b0, g}));
   assign prod = xs * gs;

   if (ROUND_NEAREST != 0) begin : g_rnd
      assign shifted = (prod + HALF) >>> FRAC;
   end else begin : g_flr
      assign shifted = prod >>> FRAC;
   end

   always_comb begin
      if (shifted > MAXV)      y = DW'(MAXV);
      else if (shifted < MINV) y = DW'(MINV);
      else                     y = DW'(shifted);
   end
endmodule

// File: rtl/alc_gain_ctrl.sv
`timescale 1ns/1ps
module alc_gain_ctrl
   import alc_pkg::*;
#(
   parameter int CW       = 8,
   parameter int CNTW     = 11,
   parameter int RST_GAIN = 145
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            smp_vld,
   input  logic            smp_msb,
   input  logic            over,
   input  logic            zc_en,
   input  logic [CNTW-1:0] tmo_len,
   input  logic [CNTW-1:0] wait_len,
   input  logic [CW-1:0]   ceil_code,
   input  logic [CW-1:0]   att_step,
   input  logic [CW-1:0]   rec_step,
   input  logic [CW-1:0]   idle_init,
   input  logic [CW-1:0]   idle_ceil,
   output logic [CW-1:0]   gain
);
   logic [CW-1:0]   gain_q, tgt_q, n_gain, n_tgt;
   logic [CNTW-1:0] zcc_q, wait_q, n_zcc, n_wait, wait_inc;
   logic            prev_q, n_prev, zc, raise;
   pend_e           pend_q, n_pend;

   assign zc       = smp_msb != prev_q;
   assign wait_inc = wait_q + CNTW'(1);

   always_comb begin
      n_gain = gain_q;
      n_tgt  = tgt_q;
      n_zcc  = zcc_q;
      n_wait = wait_q;
      n_prev = prev_q;
      n_pend = pend_q;
      raise  = 1'b0;
      if (!en) begin
         n_gain = (idle_init > idle_ceil) ? idle_ceil : idle_init;
         n_tgt  = '0;
         n_zcc  = '0;
         n_wait = '0;
         n_prev = 1'b0;
         n_pend = PEND_NONE;
      end else if (smp_vld) begin
         n_prev = smp_msb;
         if (over) begin
            n_wait = '0;
            if (pend_q != PEND_ATT) begin
               n_pend = PEND_ATT;
               n_tgt  = (gain_q > att_step) ? gain_q - att_step : '0;
               raise  = 1'b1;
            end
         end else if (pend_q == PEND_NONE && wait_inc >= wait_len && gain_q < ceil_code) begin
            n_pend = PEND_REC;
            n_tgt  = ((ceil_code - gain_q) > rec_step) ? gain_q + rec_step : ceil_code;
            n_wait = '0;
            raise  = 1'b1;
         end else begin
            n_wait = (wait_inc > wait_len) ? wait_len : wait_inc;
         end
         if (n_pend != PEND_NONE) begin
            n_zcc = raise ? CNTW'(1) : zcc_q + CNTW'(1);
            if (!zc_en || zc || n_zcc >= tmo_len) begin
               n_gain = n_tgt;
               n_pend = PEND_NONE;
               n_zcc  = '0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_q <= CW'(RST_GAIN);
         tgt_q  <= '0;
         zcc_q  <= '0;
         wait_q <= '0;
         prev_q <= 1'b0;
         pend_q <= PEND_NONE;
      end else begin
         gain_q <= n_gain;
         tgt_q  <= n_tgt;
         zcc_q  <= n_zcc;
         wait_q <= n_wait;
         prev_q <= n_prev;
         pend_q <= n_pend;
      end
   end

   assign gain = gain_q;
endmodule

// File: rtl/audio_level_ctrl.sv
`timescale 1ns/1ps
module audio_level_ctrl #(
   parameter int DW            = 16,
   parameter int CW            = 8,
   parameter int FRAC          = 12,
   parameter int UNITY_CODE    = 145,
   parameter int RST_GAIN      = 145,
   parameter int TMO_BASE      = 128,
   parameter int ROUND_NEAREST = 0,
   parameter int LIM_LVL0      = 24576,
   parameter int LIM_LVL1      = 20437,
   parameter int LIM_LVL2      = 16384,
   parameter int LIM_LVL3      = 12288
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic [1:0]    cfg_lim_sel,
   input  logic          cfg_zc_en,
   input  logic [1:0]    cfg_zc_tmo_sel,
   input  logic [1:0]    cfg_wait_sel,
   input  logic [CW-1:0] cfg_ceiling,
   input  logic [CW-1:0] cfg_init_gain,
   input  logic [1:0]    cfg_att_step_sel,
   input  logic [1:0]    cfg_rec_step_sel,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic [CW-1:0] gain
);
   localparam int GW   = FRAC + 8;
   localparam int CNTW = $clog2(TMO_BASE * 8 + 1);

   if (DW < 8)                    begin : g_chk_dw   $error("DW too small");           end
   if (UNITY_CODE >= (1 << CW))   begin : g_chk_un   $error("UNITY_CODE out of range"); end
   if (RST_GAIN >= (1 << CW))     begin : g_chk_rst  $error("RST_GAIN out of range");   end
   if (TMO_BASE < 2)              begin : g_chk_tmo  $error("TMO_BASE too small");      end
   if (LIM_LVL0 >= (1 << DW))     begin : g_chk_lim  $error("limit level too wide");    end

   // settings snapshot, loaded only while disabled
   logic [1:0]    lim_q, tmo_q, wait_q, att_q, rec_q;
   logic          zc_q;
   logic [CW-1:0] ceil_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim_q  <= '0;
         tmo_q  <= '0;
         wait_q <= '0;
         att_q  <= '0;
         rec_q  <= '0;
         zc_q   <= 1'b0;
         ceil_q <= '0;
      end else if (!en) begin
         lim_q  <= cfg_lim_sel;
         tmo_q  <= cfg_zc_tmo_sel;
         wait_q <= cfg_wait_sel;
         att_q  <= cfg_att_step_sel;
         rec_q  <= cfg_rec_step_sel;
         zc_q   <= cfg_zc_en;
         ceil_q <= cfg_ceiling;
      end
   end

   logic [CNTW-1:0]   tmo_len, wait_len;
   logic [CW-1:0]     att_step, rec_step, gain_w;
   logic [GW-1:0]     lin;
   logic signed [DW-1:0] y;
   logic [DW:0]       mag, thr;
   logic              over;

   assign tmo_len  = CNTW'(TMO_BASE) << tmo_q;
   assign wait_len = CNTW'(TMO_BASE) << wait_q;
   assign att_step = CW'(att_q) + CW'(1);
   assign rec_step = CW'(rec_q) + CW'(1);

   always_comb begin
      case (lim_q)
         2'd0:    thr = (DW+1)'(LIM_LVL0);
         2'd1:    thr = (DW+1)'(LIM_LVL1);
         2'd2:    thr = (DW+1)'(LIM_LVL2);
         default: thr = (DW+1)'(LIM_LVL3);
      endcase
   end

   alc_gain_rom #(.CW(CW), .GW(GW), .FRAC(FRAC), .UNITY(UNITY_CODE)) u_rom (
      .code (gain_w),
      .lin  (lin)
   );

   alc_scaler #(.DW(DW), .GW(GW), .FRAC(FRAC), .ROUND_NEAREST(ROUND_NEAREST)) u_scl (
      .x (in_data),
      .g (lin),
      .y (y)
   );

   assign mag  = y[DW-1] ? ((DW+1)'(0) - {y[DW-1], y}) : {1'b0, y};
   assign over = mag > thr;

   alc_gain_ctrl #(.CW(CW), .CNTW(CNTW), .RST_GAIN(RST_GAIN)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .smp_vld   (in_valid),
      .smp_msb   (in_data[DW-1]),
      .over      (over),
      .zc_en     (zc_q),
      .tmo_len   (tmo_len),
      .wait_len  (wait_len),
      .ceil_code (ceil_q),
      .att_step  (att_step),
      .rec_step  (rec_step),
      .idle_init (cfg_init_gain),
      .idle_ceil (cfg_ceiling),
      .gain      (gain_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= y;
      end
   end

   assign gain = gain_w;
endmodule

// File: rtl/audio_level_ctrl_chk.sv
`timescale 1ns/1ps
module audio_level_ctrl_chk #(
   parameter int CW       = 8,
   parameter int MAX_STEP = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic          in_valid,
   input logic          out_valid,
   input logic [CW-1:0] gain,
   input logic [CW-1:0] ceil_lock,
   input logic [CW-1:0] cfg_ceiling,
   input logic [CW-1:0] cfg_init_gain
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid) else $error("valid not forwarded"); // R1

   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid) else $error("spurious out_valid"); // R1

   AST_IDLE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (gain <= $past(cfg_ceiling) && gain <= $past(cfg_init_gain)))
      else $error("idle gain not clamped"); // R2

   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (((gain >= $past(gain)) ? (gain - $past(gain)) : ($past(gain) - gain)) <= CW'(MAX_STEP)))
      else $error("gain step too large"); // R3

   AST_RISE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (gain <= $past(gain) || gain <= ceil_lock))
      else $error("gain rose above ceiling"); // R4

   AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(ceil_lock)) else $error("settings changed while enabled"); // R7

   AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !in_valid) |=> $stable(gain)) else $error("gain moved without sample"); // R8
endmodule

bind audio_level_ctrl audio_level_ctrl_chk #(.CW(CW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .en            (en),
   .in_valid      (in_valid),
   .out_valid     (out_valid),
   .gain          (gain),
   .ceil_lock     (ceil_q),
   .cfg_ceiling   (cfg_ceiling),
   .cfg_init_gain (cfg_init_gain)
);

// File: tb/audio_level_ctrl_tb.sv
`timescale 1ns/1ps
module audio_level_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic [1:0]  cfg_lim_sel = 2'd1;
   logic        cfg_zc_en = 1'b0;
   logic [1:0]  cfg_zc_tmo_sel = 2'd0;
   logic [1:0]  cfg_wait_sel = 2'd0;
   logic [7:0]  cfg_ceiling = 8'hE1;
   logic [7:0]  cfg_init_gain = 8'h91;
   logic [1:0]  cfg_att_step_sel = 2'd0;
   logic [1:0]  cfg_rec_step_sel = 2'd0;
   logic        out_valid;
   logic [15:0] out_data;
   logic [7:0]  gain;

   int n_cmp = 0;
   int n_mis = 0;
   bit done = 0;
   string req = "R1";

   // reference model state
   int l_lim, l_zc, l_tmo, l_wait, l_ref, l_att, l_rec;
   int m_gain = 145, m_pend = 0, m_tgt = 0, m_zcc = 0, m_wait = 0, m_prev = 0;

   always #2 clk = ~clk;

   audio_level_ctrl u_dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .en               (en),
      .in_valid         (in_valid),
      .in_data          (in_data),
      .cfg_lim_sel      (cfg_lim_sel),
      .cfg_zc_en        (cfg_zc_en),
      .cfg_zc_tmo_sel   (cfg_zc_tmo_sel),
      .cfg_wait_sel     (cfg_wait_sel),
      .cfg_ceiling      (cfg_ceiling),
      .cfg_init_gain    (cfg_init_gain),
      .cfg_att_step_sel (cfg_att_step_sel),
      .cfg_rec_step_sel (cfg_rec_step_sel),
      .out_valid        (out_valid),
      .out_data         (out_data),
      .gain             (gain)
   );

   function automatic int gq(input int code);
      real g;
      g = 10.0 ** (real'(code - 145) * 0.375 / 20.0);
      return $rtoi(g * 4096.0 + 0.5);
   endfunction

   function automatic int scale(input int x, input int code);
      longint p;
      p = longint'(x) * longint'(gq(code));
      p = p >>> 12;
      if (p > 32767) p = 32767;
      if (p < -32768) p = -32768;
      return int'(p);
   endfunction

   function automatic int thr(input int sel);
      case (sel)
         0: return 24576;
         1: return 20437;
         2: return 16384;
         default: return 12288;
      endcase
   endfunction

   task automatic chk(input string r, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_mis++;
         $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
      end
   endtask

   // model of one clock edge
   task automatic model_edge(input bit v, input int x);
      int y, mag, tl, wl, step, zc, raise, over;
      if (!en) begin
         l_lim = cfg_lim_sel; l_zc = cfg_zc_en; l_tmo = cfg_zc_tmo_sel;
         l_wait = cfg_wait_sel; l_ref = cfg_ceiling; l_att = cfg_att_step_sel;
         l_rec = cfg_rec_step_sel;
         m_gain = (cfg_init_gain > cfg_ceiling) ? int'(cfg_ceiling) : int'(cfg_init_gain);
         m_pend = 0; m_tgt = 0; m_zcc = 0; m_wait = 0; m_prev = 0;
      end else if (v) begin
         y = scale(x, m_gain);
         mag = (y < 0) ? -y : y;
         over = (mag > thr(l_lim)) ? 1 : 0;
         zc = (((x >> 15) & 1) != m_prev) ? 1 : 0;
         m_prev = (x >> 15) & 1;
         tl = 128 << l_tmo;
         wl = 128 << l_wait;
         raise = 0;
         if (over != 0) begin
            m_wait = 0;
            if (m_pend != 1) begin
               step = l_att + 1;
               m_pend = 1;
               m_tgt = (m_gain > step) ? m_gain - step : 0;
               raise = 1;
            end
         end else if (m_pend == 0 && m_wait + 1 >= wl && m_gain < l_ref) begin
            step = l_rec + 1;
            m_pend = 2;
            m_tgt = (l_ref - m_gain > step) ? m_gain + step : l_ref;
            m_wait = 0;
            raise = 1;
         end else begin
            m_wait = (m_wait + 1 > wl) ? wl : m_wait + 1;
         end
         if (m_pend != 0) begin
            m_zcc = (raise != 0) ? 1 : m_zcc + 1;
            if (l_zc == 0 || zc != 0 || m_zcc >= tl) begin
               m_gain = m_tgt; m_pend = 0; m_zcc = 0;
            end
         end
      end
   endtask

   // one clock: starts and ends at a falling edge
   task automatic cyc(input bit v, input int x);
      int ey;
      in_valid = v;
      in_data = 16'(x);
      ey = scale(x, m_gain);
      model_edge(v, x);
      @(negedge clk);
      chk(req, "out_valid", int'(out_valid), int'(v));
      if (v) chk(req, "out_data", int'($signed(out_data)), ey);
      chk(req, "gain", int'(gain), m_gain);
   endtask

   task automatic quiet(input int n, input int sgn);
      for (int i = 0; i < n; i++) begin
         int a;
         a = 1 + int'($urandom % 1000);
         if (sgn > 0) cyc(1'b1, a);
         else if (sgn < 0) cyc(1'b1, -a);
         else cyc(1'b1, (($urandom % 2) != 0) ? a : -a);
      end
   endtask

   task automatic set_en(input bit b);
      en = b;
      cyc(1'b0, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R9 reset state
      repeat (3) @(negedge clk);
      req = "R9";
      chk("R9", "gain in reset", int'(gain), 145);
      chk("R9", "out_valid in reset", int'(out_valid), 0);
      chk("R9", "out_data in reset", int'(out_data), 0);
      rst_n = 1'b1;

      // R2 clamp while disabled
      req = "R2";
      cfg_init_gain = 8'hF0; cfg_ceiling = 8'hE1;
      cyc(1'b0, 0);
      chk("R2", "clamped idle gain", int'(gain), 'hE1);
      // R1 saturation at +30 dB
      req = "R1";
      cyc(1'b1, 32767);
      chk("R1", "positive saturation", int'($signed(out_data)), 32767);
      cyc(1'b1, -32768);
      chk("R1", "negative saturation", int'($signed(out_data)), -32768);
      cfg_init_gain = 8'h91;
      cyc(1'b0, 0);
      for (int i = 0; i < 40; i++) begin
         int x;
         x = int'($signed(16'($urandom)));
         cyc(1'b1, x);
         chk("R1", "unity pass-through", int'($signed(out_data)), x);
      end

      // R3 limiter with zero-crossing off
      req = "R3";
      cfg_lim_sel = 2'd1; cfg_att_step_sel = 2'd0; cfg_zc_en = 1'b0;
      set_en(1'b1);
      cyc(1'b1, 30000); cyc(1'b1, -30000); cyc(1'b1, 30000);
      chk("R3", "three single steps down", int'(gain), 'h8E);
      quiet(50, 0);

      // R4 recovery up to a low ceiling
      req = "R4";
      set_en(1'b0);
      cfg_ceiling = 8'h95; cfg_wait_sel = 2'd0; cfg_rec_step_sel = 2'd0;
      cyc(1'b0, 0);
      set_en(1'b1);
      quiet(700, 0);
      chk("R4", "gain stops at ceiling", int'(gain), 'h95);

      // R6 priority and R5 zero-crossing hold
      req = "R6";
      set_en(1'b0);
      cfg_ceiling = 8'hA0; cfg_zc_en = 1'b1; cfg_zc_tmo_sel = 2'd3;
      cyc(1'b0, 0);
      set_en(1'b1);
      quiet(128, 1);
      chk("R5", "recovery held without crossing", int'(gain), 'h91);
      cyc(1'b1, 30000);
      chk("R5", "attenuation held without crossing", int'(gain), 'h91);
      cyc(1'b1, -500);
      chk("R6", "attenuation replaced recovery", int'(gain), 'h90);
      req = "R5";
      quiet(500, -1);
      chk("R5", "recovery waits for timeout", int'(gain), 'h90);
      quiet(1200, -1);
      chk("R5", "recovery applied on timeout", int'(gain), 'h91);

      // R7 settings locked while enabled
      req = "R7";
      set_en(1'b0);
      cfg_zc_en = 1'b0; cfg_lim_sel = 2'd1; cfg_att_step_sel = 2'd0;
      cfg_ceiling = 8'hE1; cfg_init_gain = 8'h91;
      cyc(1'b0, 0);
      set_en(1'b1);
      cfg_lim_sel = 2'd3; cfg_att_step_sel = 2'd3; cfg_zc_en = 1'b1; cfg_ceiling = 8'hFF;
      cyc(1'b1, 15000);
      chk("R7", "old limit level still used", int'(gain), 'h91);
      cyc(1'b1, 30000);
      chk("R7", "old step size still used", int'(gain), 'h90);

      // random rounds, R8 via idle cycles between samples
      for (int r = 0; r < 6; r++) begin
         req = "R8";
         set_en(1'b0);
         cfg_lim_sel = 2'($urandom % 4);
         cfg_zc_en = 1'($urandom % 2);
         cfg_zc_tmo_sel = 2'($urandom % 2);
         cfg_wait_sel = 2'($urandom % 2);
         cfg_att_step_sel = 2'($urandom % 4);
         cfg_rec_step_sel = 2'($urandom % 4);
         cfg_ceiling = 8'(8'h80 + ($urandom % 8'h70));
         cfg_init_gain = 8'(8'h60 + ($urandom % 8'hA0));
         cyc(1'b0, 0);
         set_en(1'b1);
         for (int i = 0; i < 1500; i++) begin
            int k, x;
            k = int'($urandom % 4);
            case (k)
               0: x = 20000 + int'($urandom % 12768);
               1: x = int'($urandom % 2000);
               2: x = int'($urandom % 32768);
               default: x = 0;
            endcase
            if (($urandom % 2) != 0) x = -x;
            cyc(($urandom % 10) < 7, x);
         end
      end

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1;
         n_cmp++;
         n_mis++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
         $finish;
      end
   end
endmodule